// File: doc/BRIEF.md
# Receive Frame Length Limiter

This block sits in an infrared receive path between the byte output of the deframer and the write port of the receive FIFO. A start-of-frame pulse marks the beginning of each frame. An up counter tracks how many data bytes of the current frame have been passed on. When automatic packet mode is on, the count is compared with a programmed maximum length. The first byte beyond that limit is dropped, and so is every later byte of the same frame until the next start-of-frame. That first dropped byte also sets a sticky exceeded flag.

Software programs the limit and reads back the live byte count through a small byte-wide register port. The exceeded flag stays set until software reads the status register, and the read clears it. Flag and bit decoding, CRC checking and the FIFO storage itself are outside this block.

Top module: `rx_len_limiter`

## Requirements
- R1: The length limit is a 13-bit value. Bits [7:0] live at address 0, and bits [12:8] live in bits [4:0] of address 1, whose bits [7:5] read as zero. Both registers read back what was written. Writes to addresses 2 to 7 change nothing, and reads of addresses 5 to 7 return zero.
- R2: Each byte forwarded to the FIFO adds one to the frame byte count. Count bits [7:0] read at address 2, and bits [12:8] read in bits [4:0] of address 3.
- R3: In packet mode, a byte that arrives when the count is already equal to or above the limit is not written to the FIFO, and it sets the exceeded flag, which reads as bit 0 of address 4. A limit of 0 therefore drops the first byte.
- R4: After a frame has been cut, every further byte of that frame is dropped and the count stays frozen until the next start-of-frame.
- R5: A start-of-frame pulse clears the count and lifts the cut. A byte that arrives in the same cycle as the pulse is treated as the first byte of the new frame.
- R6: With packet mode off, every byte is forwarded, the count keeps counting, and the exceeded flag is never set.
- R7: The exceeded flag is sticky. Reading address 4 clears it after the read. If a new exceed event happens in the same cycle as that read, the flag stays set.
- R8: The count saturates at 8191 and does not wrap.
- R9: Bytes up to and including the limit-th byte are forwarded combinationally in the same cycle, with fifo_data_o equal to the incoming byte.
- R10: After reset the limit, the count and the flag are all zero, and no FIFO write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_mode_en | input | 1 | Enables length checking |
| sof_i | input | 1 | Start-of-frame pulse |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_data_i | input | 8 | Received byte |
| fifo_wr_o | output | 1 | Write strobe to the receive FIFO |
| fifo_data_o | output | 8 | Byte to the receive FIFO |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears the flag on address 4) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |

## Verification
The bench builds the block with its default 13-bit count and 8-bit data width. At these widths the full counter range can be reached: a directed run of more than 8192 bytes with packet mode off exercises saturation, and a limit of 8191 written through both limit registers exercises the high-byte field. Random frames use small limits so that cutoffs, start-of-frame pulses that coincide with a byte, and status reads that coincide with an exceed event all occur many times.

// File: rtl/rxl_pkg.sv
package rxl_pkg;

    localparam int DATA_W = 8;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_LIM_LO = 3'd0,
        RA_LIM_HI = 3'd1,
        RA_CNT_LO = 3'd2,
        RA_CNT_HI = 3'd3,
        RA_STAT   = 3'd4
    } reg_addr_e;

    localparam int STAT_EXC_BIT = 0;

    typedef struct packed {
        logic              sof;
        logic              vld;
        logic [DATA_W-1:0] data;
    } rx_evt_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [REG_AW-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    function automatic logic [DATA_W-1:0] zext_hi(input logic [DATA_W-1:0] v, input int w);
        logic [DATA_W-1:0] m;
        m = (w >= DATA_W) ? '1 : ((DATA_W)'(1) << w) - 1'b1;
        return v & m;
    endfunction

endpackage

// File: rtl/rxl_frame_cnt.sv
module rxl_frame_cnt
    import rxl_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_en,
    input  rx_evt_t          evt,
    input  logic [CNT_W-1:0] limit,
    output logic             accept,
    output logic             drop_first,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             cut_q;
    logic [CNT_W-1:0] base;
    logic             blk;
    logic             at_lim;

    always_comb begin
        base       = evt.sof ? '0 : cnt_q;
        blk        = evt.sof ? 1'b0 : cut_q;
        at_lim     = (base >= limit);
        accept     = evt.vld && (!mode_en || (!blk && !at_lim));
        drop_first = evt.vld && mode_en && !blk && at_lim;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cut_q <= 1'b0;
        end else begin
            if (evt.sof) begin
                cnt_q <= '0;
                cut_q <= 1'b0;
            end
            if (accept && base != CNT_MAX) cnt_q <= base + 1'b1;
            if (drop_first) cut_q <= 1'b1;
        end
    end

    AST_CUT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (cut_q && mode_en && !evt.sof) |-> !accept); // R4
    AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (evt.sof && !evt.vld) |=> (cnt_q == '0)); // R5
    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !evt.sof) |=> (cnt_q == CNT_MAX)); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (accept && !evt.sof && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

endmodule

// File: rtl/rxl_regs.sv
module rxl_regs
    import rxl_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              drop_first,
    output logic [CNT_W-1:0]  limit,
    output logic              exc_q,
    output logic [DATA_W-1:0] rdata
);
    localparam int HI_W = CNT_W - DATA_W;

    logic [DATA_W-1:0] lim_lo_q;
    logic [HI_W-1:0]   lim_hi_q;
    logic              rd_stat;

    assign limit   = {lim_hi_q, lim_lo_q};
    assign rd_stat = req.rd && (req.addr == RA_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_lo_q <= '0;
            lim_hi_q <= '0;
            exc_q    <= 1'b0;
        end else begin
            if (req.wr && req.addr == RA_LIM_LO) lim_lo_q <= req.wdata;
            if (req.wr && req.addr == RA_LIM_HI) lim_hi_q <= req.wdata[HI_W-1:0];
            if (drop_first)   exc_q <= 1'b1;
            else if (rd_stat) exc_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (req.addr)
            RA_LIM_LO: rdata = lim_lo_q;
            RA_LIM_HI: rdata = zext_hi(DATA_W'(lim_hi_q), HI_W);
            RA_CNT_LO: rdata = cnt[DATA_W-1:0];
            RA_CNT_HI: rdata = zext_hi(DATA_W'(cnt[CNT_W-1:DATA_W]), HI_W);
            RA_STAT:   rdata[STAT_EXC_BIT] = exc_q;
            default:   rdata = '0;
        endcase
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (exc_q && !rd_stat) |=> exc_q); // R7
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !drop_first) |=> !exc_q); // R7

endmodule

// File: rtl/rx_len_limiter.sv
module rx_len_limiter
    import rxl_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_mode_en,
    input  logic              sof_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_data_i,
    output logic              fifo_wr_o,
    output logic [DATA_W-1:0] fifo_data_o,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o
);
    rx_evt_t          evt;
    reg_req_t         req;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic             drop_first;
    logic             exc;

    assign evt = '{sof: sof_i, vld: byte_vld_i, data: byte_data_i};
    assign req = '{wr: reg_wr_i, rd: reg_rd_i, addr: reg_addr_i, wdata: reg_wdata_i};

    rxl_frame_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .mode_en(pkt_mode_en), .evt(evt), .limit(limit),
        .accept(accept), .drop_first(drop_first), .cnt_q(cnt)
    );

    rxl_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .req(req), .cnt(cnt), .drop_first(drop_first),
        .limit(limit), .exc_q(exc), .rdata(reg_rdata_o)
    );

    assign fifo_wr_o   = accept;
    assign fifo_data_o = evt.data;

    AST_DROP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        drop_first |=> exc); // R3
    AST_OFF_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        (!pkt_mode_en && byte_vld_i) |-> fifo_wr_o); // R6
    AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (rst)
        !byte_vld_i |-> !fifo_wr_o); // R9

endmodule

// File: tb/sim_rx_len_limiter.sv
module sim_rx_len_limiter;
    localparam int PERIOD = 10;
    localparam int CW = 13;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic clk = 0, rst = 1;
    logic mode = 0, sof = 0, vld = 0;
    logic [7:0] din = 0;
    logic fwr;
    logic [7:0] fdat;
    logic rwr = 0, rrd = 0;
    logic [2:0] radr = 0;
    logic [7:0] rwd = 0, rdat;

    int checks = 0, errors = 0;
    logic [CW-1:0] m_lim = 0, m_cnt = 0;
    logic m_cut = 0, m_flag = 0;

    always #(PERIOD/2) clk = ~clk;

    rx_len_limiter #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .pkt_mode_en(mode), .sof_i(sof), .byte_vld_i(vld),
        .byte_data_i(din), .fifo_wr_o(fwr), .fifo_data_o(fdat), .reg_wr_i(rwr),
        .reg_rd_i(rrd), .reg_addr_i(radr), .reg_wdata_i(rwd), .reg_rdata_o(rdat)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_accept(input bit md, input bit s, input bit v);
        logic [CW-1:0] b = s ? '0 : m_cnt;
        bit k = s ? 1'b0 : m_cut;
        return v && (!md || (!k && b < m_lim));
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_lim[7:0];
            3'd1: return {3'b0, m_lim[12:8]};
            3'd2: return m_cnt[7:0];
            3'd3: return {3'b0, m_cnt[12:8]};
            3'd4: return {7'b0, m_flag};
            default: return 8'h00;
        endcase
    endfunction

    // one clock cycle with all inputs; checks combinational outputs, then updates model
    task automatic cyc(input bit s, input bit v, input logic [7:0] d,
                       input bit w, input bit r, input logic [2:0] a, input logic [7:0] wd,
                       input string req);
        bit acc, dropf;
        logic [CW-1:0] b;
        @(negedge clk);
        sof = s; vld = v; din = d; rwr = w; rrd = r; radr = a; rwd = wd;
        #1;
        acc = exp_accept(mode, s, v);
        check(fwr == acc, req, fwr, acc);
        if (acc) check(fdat == d, "R9", fdat, d);
        if (r) check(rdat == exp_read(a), req, rdat, exp_read(a));
        @(posedge clk);
        b = s ? '0 : m_cnt;
        dropf = v && mode && !(s ? 1'b0 : m_cut) && (b >= m_lim);
        if (s) begin m_cnt = '0; m_cut = 0; end
        if (acc && b != CMAX) m_cnt = b + 1'b1;
        if (dropf) begin m_cut = 1; m_flag = 1; end
        else if (r && a == 3'd4) m_flag = 0;
        if (w && a == 3'd0) m_lim[7:0] = wd;
        if (w && a == 3'd1) m_lim[12:8] = wd[4:0];
    endtask

    task automatic rd(input logic [2:0] a, input string req);
        cyc(0, 0, 0, 0, 1, a, 0, req);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] wd);
        cyc(0, 0, 0, 1, 0, a, wd, "R1");
    endtask

    task automatic set_lim(input int l);
        wr(0, l[7:0]); wr(1, l[15:8]);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R10 reset state
        #1 check(fwr == 0, "R10", fwr, 0);
        for (int a = 0; a < 8; a++) rd(a[2:0], "R10");
        // R1 limit readback, high bits masked, read-only writes ignored
        set_lim(8191);
        rd(0, "R1"); rd(1, "R1");
        wr(1, 8'hFF); rd(1, "R1");
        wr(2, 8'h55); wr(3, 8'h55); wr(4, 8'h01); wr(6, 8'h77);
        for (int a = 2; a < 8; a++) rd(a[2:0], "R1");
        // R3 limit 0 drops first byte
        mode = 1; set_lim(0);
        cyc(1, 1, 8'hA5, 0, 0, 0, 0, "R3");
        rd(4, "R3"); rd(4, "R7");
        // R9/R3/R4: limit 3
        set_lim(3);
        cyc(1, 0, 0, 0, 0, 0, 0, "R5");
        for (int i = 0; i < 6; i++) cyc(0, 1, 8'(i + 16), 0, 0, 0, 0, i < 3 ? "R9" : "R4");
        rd(2, "R4"); rd(4, "R3");
        // R5 sof with byte counts as first byte
        cyc(1, 1, 8'h3C, 0, 0, 0, 0, "R5");
        rd(2, "R5");
        // R7 exceed coincident with status read: flag stays set
        cyc(0, 1, 1, 0, 0, 0, 0, "R9"); cyc(0, 1, 2, 0, 0, 0, 0, "R9");
        cyc(0, 1, 3, 0, 1, 4, 0, "R7");
        rd(4, "R7"); rd(4, "R7");
        // R6 mode off forwards everything, no flag
        mode = 0;
        for (int i = 0; i < 10; i++) cyc(0, 1, 8'(i), 0, 0, 0, 0, "R6");
        rd(2, "R6"); rd(4, "R6");
        // R8 saturation
        cyc(1, 0, 0, 0, 0, 0, 0, "R5");
        for (int i = 0; i < 8200; i++) cyc(0, 1, 8'(i), 0, 0, 0, 0, "R8");
        rd(2, "R8"); rd(3, "R8");
        // R2 large limit through high byte
        mode = 1; set_lim(300);
        cyc(1, 0, 0, 0, 0, 0, 0, "R5");
        for (int i = 0; i < 305; i++) cyc(0, 1, 8'(i), 0, 0, 0, 0, "R2");
        rd(2, "R2"); rd(3, "R2"); rd(4, "R3");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int k = $urandom_range(0, 99);
            if (k < 3) mode = $urandom_range(0, 1);
            if (k < 5) set_lim($urandom_range(0, 12));
            else if (k < 12) rd(3'($urandom_range(0, 7)), "R2");
            else cyc($urandom_range(0, 9) == 0, $urandom_range(0, 3) != 0, 8'($urandom),
                     0, $urandom_range(0, 15) == 0, 3'd4, 0, "R4");
        end
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule